// File: doc/BRIEF.md
# Device Mailbox Register Slice

This block is the register slice behind a device command mailbox. A host reaches it over a simple little-endian bus. Each request carries an address, a size code and up to eight bytes of right-justified write data. The block turns the size and the low address bits into byte-lane enables. Reads return their bytes right-justified, one cycle after the request.

Beside the payload buffer, the slice holds a capability word, a control word whose bit 0 is the doorbell, a 64-bit command word, a 64-bit status word, a background-status word and a memory-device status word. Where a write lands depends on both its offset and its width.

When software leaves the doorbell set and no command is in flight, the block pulses `cmd_start` to an external command processor. It then holds off further starts until the processor answers with `cmd_done` and a return code.

Top module: `mbox_regs`

Address map (byte offsets): capability 0x00, control 0x04, command 0x08, status 0x10, background status 0x18, payload 0x20 to 0x81F, memory-device status 0x1000.

## Requirements
- R1: `req_size` encodes the width as 0=1, 1=2, 2=4 and 3=8 bytes. A read sets `rd_valid` in the next cycle, and `rd_data` holds the addressed bytes little-endian and right-justified, with the unused upper bytes zero.
- R2: An access whose address is not a multiple of its width pulses `err_pulse` in the next cycle. It changes no register, and if it is a read it returns zero data.
- R3: A 4-byte write is stored only at offset 0x00 (capability) or 0x04 (control). A 4-byte write to 0x08, 0x10 or 0x18 is dropped. A 1- or 2-byte write below 0x20 is dropped and pulses `err_pulse`.
- R4: An 8-byte write is stored only at 0x08 (command, also driven on `cmd_word`). An 8-byte write to 0x00, 0x10 or 0x18 is dropped.
- R5: A write of any legal width at an aligned offset from 0x20 up to 0x81F is stored byte for byte into the payload buffer at that offset.
- R6: The status word changes only on an accepted completion. It then becomes the return code in bits 47:32, with every other bit zero.
- R7: After reset, the capability word reads 0x0000000B. Bits 4:0 give log2 of the payload size (11, so 2048 bytes), bit 5 is interrupt support (0) and bit 6 is background-command support (0). Every other register and every payload byte reads zero.
- R8: In any cycle where control bit 0 is 1 after the current write and no command is in flight, `cmd_start` is high for exactly one cycle, in the cycle after that write.
- R9: While a command is in flight, no further `cmd_start` occurs. `cmd_done` during flight stores the status word, clears control bit 0 and ends the flight. `cmd_done` while idle has no effect.
- R10: The memory-device status word at 0x1000 always reads 0x14 (media ready in bit 2, mailbox ready in bit 4). Writes to it have no effect.
- R11: If a control write and an accepted `cmd_done` fall in the same cycle, the written control bits are kept except bit 0, which ends up 0. A status read in the completion cycle returns the value from before the completion.
- R12: Reads of unmapped offsets return zero, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset of the access |
| req_size | input | 2 | Width code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_wdata | input | 64 | Right-justified write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Right-justified read data |
| err_pulse | output | 1 | One-cycle strobe for an illegal access |
| cmd_start | output | 1 | One-cycle pulse handing a command to the processor |
| cmd_word | output | 64 | Current command word |
| cmd_done | input | 1 | Completion from the processor |
| cmd_rc | input | 16 | Return code delivered with `cmd_done` |

## Verification
Two events can land in the same cycle: the processor's completion, and a host access to the control or status word. The bench drives `cmd_done` in the very cycle that a write to the control word is presented. It then expects the written upper bits to survive while the doorbell still ends cleared. In a second case, the bench presents a status read together with a completion. Its reference model computes the read data before it applies the completion, so the read must return the old status and the next read the new one.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_CORE = 2'd0,
        RG_PLD  = 2'd1,
        RG_MDEV = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic       err;
        logic       wr;
        logic       rd;
        region_e    rgn;
        acc_size_e  size;
        logic [2:0] lane;
        logic [1:0] reg_word;
        logic [7:0] be;
        logic [63:0] wlane;
    } acc_t;

    localparam int unsigned CORE_WORDS = 4;
    localparam int unsigned PLD_BASE   = CORE_WORDS * 8;
    localparam logic [63:0] MDEV_VALUE = 64'h0000_0000_0000_0014;

    function automatic logic is_aligned(acc_size_e s, logic [2:0] lane);
        case (s)
            SZ_B:    return 1'b1;
            SZ_H:    return !lane[0];
            SZ_W:    return lane[1:0] == 2'b00;
            default: return lane == 3'b000;
        endcase
    endfunction

    function automatic logic [7:0] lane_mask(acc_size_e s, logic [2:0] lane);
        logic [15:0] base;
        case (s)
            SZ_B:    base = 16'h0001;
            SZ_H:    base = 16'h0003;
            SZ_W:    base = 16'h000F;
            default: base = 16'h00FF;
        endcase
        return 8'(base << lane);
    endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PLD_BYTES = 2048,
    parameter int MDEV_ADDR = 4096,
    parameter int IDX_W     = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output acc_t              acc,
    output logic [IDX_W-1:0]  pld_idx
);
    localparam int unsigned PLD_WBASE = PLD_BASE / 8;
    localparam int unsigned PLD_WEND  = PLD_WBASE + PLD_BYTES / 8;
    localparam int unsigned MDEV_W    = MDEV_ADDR / 8;

    int unsigned wai;
    acc_size_e   sz;
    logic [2:0]  lane;
    logic        misalign;
    logic        narrow;
    region_e     rgn;

    always_comb begin
        sz   = acc_size_e'(req_size);
        lane = req_addr[2:0];
        wai  = 32'(req_addr[ADDR_W-1:3]);
        if (wai < CORE_WORDS)      rgn = RG_CORE;
        else if (wai < PLD_WEND)   rgn = RG_PLD;
        else if (wai == MDEV_W)    rgn = RG_MDEV;
        else                       rgn = RG_NONE;

        misalign = !is_aligned(sz, lane);
        narrow   = req_write && (rgn == RG_CORE) && (sz == SZ_B || sz == SZ_H);

        acc          = '0;
        acc.err      = req_valid && (misalign || narrow);
        acc.wr       = req_valid && req_write && !acc.err;
        acc.rd       = req_valid && !req_write;
        acc.rgn      = rgn;
        acc.size     = sz;
        acc.lane     = lane;
        acc.reg_word = req_addr[4:3];
        acc.be       = lane_mask(sz, lane);
        acc.wlane    = req_wdata << {lane, 3'b000};
        pld_idx      = IDX_W'(wai - PLD_WBASE);
    end
endmodule

// File: rtl/mbox_payload.sv
module mbox_payload #(
    parameter int WORDS = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       be,
    input  logic [63:0]      wlane,
    output logic [63:0]      rdata
);
    logic [63:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (we) begin
            for (int b = 0; b < 8; b++) begin
                if (be[b]) mem[idx][b*8 +: 8] <= wlane[b*8 +: 8];
            end
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/mbox_core_regs.sv
module mbox_core_regs
    import mbox_pkg::*;
#(
    parameter int PLD_LOG2 = 11,
    parameter int RC_W     = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [1:0]      reg_word,
    input  acc_size_e       size,
    input  logic [7:0]      be,
    input  logic [63:0]     wlane,
    input  logic            done,
    input  logic [RC_W-1:0] rc,
    output logic [31:0]     cap_q,
    output logic [31:0]     ctrl_q,
    output logic [63:0]     cmd_q,
    output logic [63:0]     sts_q,
    output logic            start_q
);
    localparam logic [31:0] CAP_RST = {25'd0, 1'b0, 1'b0, 5'(PLD_LOG2)};

    logic        busy_q;
    logic [31:0] cap_d, ctrl_d;
    logic [63:0] cmd_d, sts_d;
    logic        busy_d, start_d;

    always_comb begin
        cap_d   = cap_q;
        ctrl_d  = ctrl_q;
        cmd_d   = cmd_q;
        sts_d   = sts_q;
        busy_d  = busy_q;
        start_d = 1'b0;
        if (wr && size == SZ_W && reg_word == 2'd0) begin
            if (be[3:0] == 4'hF) cap_d  = wlane[31:0];
            if (be[7:4] == 4'hF) ctrl_d = wlane[63:32];
        end
        if (wr && size == SZ_D && reg_word == 2'd1) cmd_d = wlane;
        if (ctrl_d[0] && !busy_q) begin
            start_d = 1'b1;
            busy_d  = 1'b1;
        end
        if (done && busy_q) begin
            sts_d = '0;
            sts_d[32 +: RC_W] = rc;
            ctrl_d[0] = 1'b0;
            busy_d    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= CAP_RST;
            ctrl_q  <= '0;
            cmd_q   <= '0;
            sts_q   <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            cap_q   <= cap_d;
            ctrl_q  <= ctrl_d;
            cmd_q   <= cmd_d;
            sts_q   <= sts_d;
            busy_q  <= busy_d;
            start_q <= start_d;
        end
    end

    // R8: start is a single-cycle strobe
    p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q) else $error("start longer than one cycle");

    // R9: completion in flight ends the flight and drops the doorbell
    p_done_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (done && busy_q) |=> (!ctrl_q[0] && !busy_q)) else $error("doorbell kept after done");

    // R6: status moves only on an accepted completion
    p_sts_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(done && busy_q) |=> $stable(sts_q)) else $error("status changed without done");

    // R7: capability holds its reset value right after reset
    p_cap_reset_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cap_q == CAP_RST)) else $error("capability reset value wrong");
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PLD_BYTES = 2048,
    parameter int MDEV_ADDR = 4096,
    parameter int RC_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              err_pulse,
    output logic              cmd_start,
    output logic [63:0]       cmd_word,
    input  logic              cmd_done,
    input  logic [RC_W-1:0]   cmd_rc
);
    localparam int PLD_WORDS = PLD_BYTES / 8;
    localparam int IDX_W     = $clog2(PLD_WORDS);
    localparam int PLD_LOG2  = $clog2(PLD_BYTES);

    acc_t             acc;
    logic [IDX_W-1:0] pld_idx;
    logic [63:0]      pld_rdata;
    logic [31:0]      cap_q, ctrl_q;
    logic [63:0]      cmd_q, sts_q;
    logic [63:0]      word, shifted, keep;
    logic [3:0]       nb;

    mbox_decode #(
        .ADDR_W(ADDR_W), .PLD_BYTES(PLD_BYTES), .MDEV_ADDR(MDEV_ADDR), .IDX_W(IDX_W)
    ) u_dec (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .acc(acc), .pld_idx(pld_idx)
    );

    mbox_payload #(.WORDS(PLD_WORDS), .IDX_W(IDX_W)) u_pld (
        .clk(clk), .rst(rst), .we(acc.wr && acc.rgn == RG_PLD), .idx(pld_idx),
        .be(acc.be), .wlane(acc.wlane), .rdata(pld_rdata)
    );

    mbox_core_regs #(.PLD_LOG2(PLD_LOG2), .RC_W(RC_W)) u_core (
        .clk(clk), .rst(rst), .wr(acc.wr && acc.rgn == RG_CORE), .reg_word(acc.reg_word),
        .size(acc.size), .be(acc.be), .wlane(acc.wlane), .done(cmd_done), .rc(cmd_rc),
        .cap_q(cap_q), .ctrl_q(ctrl_q), .cmd_q(cmd_q), .sts_q(sts_q), .start_q(cmd_start)
    );

    always_comb begin
        case (acc.rgn)
            RG_CORE: begin
                case (acc.reg_word)
                    2'd0:    word = {ctrl_q, cap_q};
                    2'd1:    word = cmd_q;
                    2'd2:    word = sts_q;
                    default: word = '0;
                endcase
            end
            RG_PLD:  word = pld_rdata;
            RG_MDEV: word = MDEV_VALUE;
            default: word = '0;
        endcase
        shifted = word >> {acc.lane, 3'b000};
        nb      = 4'd1 << acc.size;
    end

    for (genvar b = 0; b < 8; b++) begin : g_keep
        assign keep[b*8 +: 8] = (4'(b) < nb) ? 8'hFF : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            err_pulse <= 1'b0;
        end else begin
            rd_valid  <= acc.rd;
            rd_data   <= (acc.rd && !acc.err) ? (shifted & keep) : '0;
            err_pulse <= acc.err;
        end
    end

    assign cmd_word = cmd_q;

    // R1: every read is answered in the next cycle
    p_rd_resp_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid) else $error("missing read response");

    // R2: a misaligned 8-byte access raises the error strobe
    p_misalign_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd3 && req_addr[2:0] != 3'd0) |=> err_pulse)
        else $error("misaligned access not flagged");

    // R3: narrow write into the register words raises the error strobe
    p_narrow_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size < 2'd2 && req_addr < ADDR_W'(PLD_BASE)) |=> err_pulse)
        else $error("narrow register write not flagged");

    // R10: memory-device status word reads a fixed value
    p_mdev_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd3 && req_addr == ADDR_W'(MDEV_ADDR))
        |=> (rd_data == MDEV_VALUE)) else $error("memory-device status wrong");
endmodule

// File: tb/test_mbox_regs.sv
module test_mbox_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [12:0] req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata;
    logic        rd_valid, err_pulse, cmd_start, cmd_done;
    logic [63:0] rd_data, cmd_word;
    logic [15:0] cmd_rc;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] mb [0:8191];
    bit         m_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_regs i_mbox_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_pulse(err_pulse),
        .cmd_start(cmd_start), .cmd_word(cmd_word), .cmd_done(cmd_done), .cmd_rc(cmd_rc)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_cmd();
        logic [63:0] v = '0;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = mb[8+i];
        return v;
    endfunction

    task automatic model_write(input int a, input int n, input logic [63:0] wd);
        bit store = 0;
        if (a >= 32 && a < 32 + 2048) store = 1;
        else if (a < 32 && n == 4 && (a == 0 || a == 4)) store = 1;
        else if (a < 32 && n == 8 && a == 8) store = 1;
        if (store) for (int i = 0; i < n; i++) mb[a+i] = wd[i*8 +: 8];
    endtask

    task automatic cyc(input bit v, input bit w, input int a, input int sz,
                       input logic [63:0] wd, input bit dn, input logic [15:0] rc,
                       input string tag);
        int          n = 1 << sz;
        bit          mis = (a % n) != 0;
        bit          e_rv = v && !w;
        bit          e_err = 0;
        bit          e_start = 0;
        bit          busy_old = m_busy;
        logic [63:0] e_rd = '0;
        if (v) begin
            if (mis || (w && a < 32 && n < 4)) e_err = 1;
            else if (!w) begin
                for (int i = 0; i < n; i++) e_rd |= 64'(mb[a+i]) << (8*i);
            end else model_write(a, n, wd);
        end
        if (!busy_old && mb[4][0]) begin
            e_start = 1;
            m_busy  = 1;
        end
        if (dn && busy_old) begin
            for (int i = 0; i < 8; i++) mb[16+i] = 8'h00;
            mb[20]   = rc[7:0];
            mb[21]   = rc[15:8];
            mb[4][0] = 1'b0;
            m_busy   = 0;
        end
        req_valid = v; req_write = w; req_addr = 13'(a); req_size = 2'(sz);
        req_wdata = wd; cmd_done = dn; cmd_rc = rc;
        @(posedge clk);
        #1;
        chk(rd_valid == e_rv, tag, "rd_valid", 64'(rd_valid), 64'(e_rv));
        if (e_rv) chk(rd_data == e_rd, tag, "rd_data", rd_data, e_rd);
        chk(err_pulse == e_err, tag, "err_pulse", 64'(err_pulse), 64'(e_err));
        chk(cmd_start == e_start, tag, "cmd_start", 64'(cmd_start), 64'(e_start));
        chk(cmd_word == model_cmd(), tag, "cmd_word", cmd_word, model_cmd());
        @(negedge clk);
        req_valid = 0; cmd_done = 0;
    endtask

    task automatic wr(input int a, input int sz, input logic [63:0] d, input string tag);
        cyc(1, 1, a, sz, d, 0, 16'h0, tag);
    endtask

    task automatic rd(input int a, input int sz, input string tag);
        cyc(1, 0, a, sz, 64'h0, 0, 16'h0, tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 64'h0, 0, 16'h0, tag);
    endtask

    task automatic done(input logic [15:0] rc, input string tag);
        cyc(0, 0, 0, 0, 64'h0, 1, rc, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8192; i++) mb[i] = 8'h00;
        mb[0]    = 8'h0B;
        mb[4096] = 8'h14;
        m_busy   = 0;
        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_size = '0;
        req_wdata = '0; cmd_done = 0; cmd_rc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R7: reset values
        idle("R7");
        rd(0, 2, "R7");  rd(4, 2, "R7");  rd(8, 3, "R7");  rd(16, 3, "R7");
        rd(24, 3, "R7"); rd(32, 3, "R7"); rd(2072, 3, "R7");

        // R3: 4-byte steering and narrow-write rejection
        wr(0, 2, 64'h5A5A_0040, "R3");
        wr(4, 2, 64'h0000_0006, "R3");
        rd(0, 3, "R3"); rd(4, 2, "R3");
        wr(8, 2, 64'hFFFF_FFFF, "R3");
        wr(16, 2, 64'hFFFF_FFFF, "R3");
        wr(24, 2, 64'hFFFF_FFFF, "R3");
        wr(4, 0, 64'hFF, "R3");
        wr(6, 1, 64'hFFFF, "R3");
        rd(4, 2, "R3"); rd(8, 3, "R3"); rd(16, 3, "R3");

        // R4: 8-byte steering
        wr(8, 3, 64'h1122_3344_5566_7788, "R4");
        wr(16, 3, 64'hDEAD_BEEF_DEAD_BEEF, "R4");
        wr(24, 3, 64'hDEAD_BEEF_DEAD_BEEF, "R4");
        wr(0, 3, 64'hFFFF_FFFF_FFFF_FFFE, "R4");
        rd(8, 3, "R4"); rd(16, 3, "R4"); rd(24, 3, "R4"); rd(0, 3, "R4");

        // R1: partial reads of the command word
        rd(12, 2, "R1"); rd(10, 1, "R1"); rd(15, 0, "R1");

        // R5: payload writes of every width, including the last byte
        wr(32, 0, 64'hAB, "R5");
        wr(34, 1, 64'hCDEF, "R5");
        wr(36, 2, 64'h0123_4567, "R5");
        wr(40, 3, 64'h8877_6655_4433_2211, "R5");
        wr(2072, 2, 64'hCAFE_F00D, "R5");
        wr(2079, 0, 64'h99, "R5");
        rd(32, 3, "R5"); rd(40, 3, "R5"); rd(2072, 3, "R5");
        rd(2079, 0, "R5"); rd(33, 0, "R5"); rd(44, 2, "R5");

        // R2: misaligned accesses
        wr(33, 1, 64'hFFFF, "R2");
        wr(34, 2, 64'hFFFF_FFFF, "R2");
        wr(36, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        rd(35, 1, "R2"); rd(12, 3, "R2");
        rd(32, 3, "R2"); rd(40, 3, "R2");

        // R8, R9: doorbell and completion handshake
        wr(4, 2, 64'h1, "R8");
        idle("R9");
        wr(4, 2, 64'h1, "R9");
        wr(8, 3, 64'h0000_0000_0000_0A5A, "R9");
        done(16'h1234, "R9");
        rd(16, 3, "R6"); rd(4, 2, "R9");
        done(16'hBEEF, "R9");
        rd(16, 3, "R6");

        // R11: completion collides with a control write
        wr(4, 2, 64'h1, "R8");
        cyc(1, 1, 4, 2, 64'h0000_00F1, 1, 16'h0042, "R11");
        rd(4, 2, "R11");
        wr(4, 2, 64'h0000_00F1, "R8");
        cyc(1, 0, 16, 3, 64'h0, 1, 16'h0007, "R11");
        rd(16, 3, "R11"); rd(4, 2, "R11");

        // R10: memory-device status
        rd(4096, 3, "R10"); rd(4096, 0, "R10");
        wr(4096, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
        rd(4096, 3, "R10");

        // R12: unmapped space
        wr(2304, 3, 64'h1234_5678_9ABC_DEF0, "R12");
        rd(2304, 3, "R12"); rd(4104, 2, "R12");
        idle("R12");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule